// File: doc/BRIEF.md
# Smart Panel Command Sequencer

This block executes a stream of 16-bit command words against a display panel that has its own frame memory and is driven over an 8080-style parallel bus. The bus has an active-low chip select, an A0 line that separates commands from data, active-low read and write strobes, and an 8-bit data bus with an output enable. A bus master outside the block fills the command stream. The sequencer takes one word at a time, decodes it and runs the matching bus operation. The operations are a single command or data byte write, a pixel stream write, a status or frame-memory read, a wait for vertical sync, a no-op, and an in-stream interrupt marker.

Each bus transfer runs as a sequence of timed phases: address/select setup, strobe, hold, and an inhibit gap after every write. The length of each phase comes from a programmable cycle count, and a count of zero is treated as one. After a read, the byte that was read, its A0 source and an OK flag are placed in a read-status word. The sequencer then stalls until software sets the continue flag. A sticky, write-1-to-clear status word records completed reads, interrupt markers and undefined opcodes. The interrupt output follows the interrupt-marker bit.

The decoder finds the opcode in bits [11:9], the A0 level in bit 8 and the bus byte in bits [7:0]. Software is expected to pad odd-length streams with a no-op so that words stay paired, and to end each stream with an interrupt marker followed by a vsync wait.

Top module: `spnl_seq`

## Requirements
- R1: After reset, and while `enable` is low, the bus is idle (`pnl_cs_n`, `pnl_rd_n` and `pnl_wr_n` high, `pnl_oe` low), `cmd_ready` and `pix_ready` are low, and `status`, `rdstat` and `irq` are zero after reset.
- R2: Opcode 1 (bits [11:9] = 1) performs one write. A0 equals bit 8 (0 = command byte, 1 = data byte), `pnl_dout` carries bits [7:0] while `pnl_wr_n` is low, and the data bus is driven only while chip select is active.
- R3: Every transfer holds chip select active with both strobes high for max(1,`t_setup`) cycles before the strobe. The strobe lasts max(1,`t_pulse`) cycles. For a write, chip select then stays active for max(1,`t_setup`) cycles, so a programmed zero behaves as one.
- R4: After a write, chip select stays high for at least max(1,`t_inhibit`) cycles before the next transfer begins.
- R5: Opcode 0 performs a read with A0 = bit 8 (0 = panel status, 1 = frame memory). `pnl_oe` is low throughout, and chip select stays active for max(1,`t_ohold`) cycles after the read strobe rises. The byte sampled in the last strobe cycle goes to `rdstat[7:0]`, A0 goes to `rdstat[8]`, `rdstat[9]` (OK) is set, and `status[11]` is set.
- R6: After a read, no further command is accepted until the continue flag `rdstat[10]` is set by `cont_set`. A flag that is set before the read ends lets the sequence go on without another action. Going on clears `rdstat[9]` and `rdstat[10]`.
- R7: Opcode 2 streams pixel bytes from the pixel interface. Each byte becomes one write with A0 high. The stream ends after the byte flagged `pix_last`.
- R8: Opcode 3 accepts no further command until a `vsync` pulse or a `wait_abort` pulse arrives.
- R9: Opcode 4 causes no bus activity and no status change.
- R10: Opcode 5 sets `status[12]` and `irq` without bus activity. Status bits are cleared by writing 1 through `sts_clr_we`/`sts_clr`. If a set and a clear of the same bit fall in one cycle, the set wins.
- R11: Opcodes 6 and 7 cause no bus activity and set the sticky error bit `status[13]`.
- R12: If `enable` falls during a transfer, the current phase runs to its full length. The bus then returns directly to idle, with no later phase and no further command accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Sequencer enable |
| cmd_valid | input | 1 | Command word available |
| cmd_word | input | 16 | Command word |
| cmd_ready | output | 1 | Command word accepted this cycle when valid |
| pix_valid | input | 1 | Pixel byte available |
| pix_data | input | 8 | Pixel byte |
| pix_last | input | 1 | Final pixel byte of a frame write |
| pix_ready | output | 1 | Pixel byte accepted this cycle when valid |
| vsync | input | 1 | Vertical sync event pulse |
| wait_abort | input | 1 | Ends a pending vsync wait |
| cont_set | input | 1 | Sets the continue flag after a read |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr | input | 16 | Write-1-to-clear mask for `status` |
| t_setup | input | TW | Select/A0 setup and write hold, in cycles |
| t_pulse | input | TW | Strobe width, in cycles |
| t_ohold | input | TW | Hold after read strobe, in cycles |
| t_inhibit | input | TW | Gap after a write, in cycles |
| status | output | 16 | Sticky status: bit 11 read done, bit 12 interrupt marker, bit 13 bad opcode |
| rdstat | output | 11 | Read status: [7:0] byte, [8] A0, [9] OK, [10] continue |
| irq | output | 1 | Interrupt, high while `status[12]` is set |
| pnl_cs_n | output | 1 | Panel chip select, active low |
| pnl_a0 | output | 1 | Panel command/data select |
| pnl_rd_n | output | 1 | Read strobe, active low |
| pnl_wr_n | output | 1 | Write strobe, active low |
| pnl_oe | output | 1 | Data bus output enable |
| pnl_dout | output | 8 | Data bus out |
| pnl_din | input | 8 | Data bus in |

## Verification
The interrupt marker and the software clear of the status word can meet in one cycle. Both update `status[12]`, one as a set and one as a write-1 clear. The bench makes them meet by waiting until the sequencer is idle and ready. In that same cycle it presents an opcode-5 word together with a clear strobe for bit 12, while the bit is already set. The result is judged correct if bit 12 and `irq` are still high afterwards.

// File: rtl/spnl_pkg.sv
package spnl_pkg;

    localparam int CMD_W      = 16;
    localparam int BYTE_W     = 8;
    localparam int A0_POS     = 8;
    localparam int OP_LSB     = 9;
    localparam int OP_W       = 3;
    localparam int RDST_W     = BYTE_W + 3;
    localparam int FLAG_LSB   = 11;
    localparam int FLAG_N     = 3;

    typedef enum logic [OP_W-1:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_FRAME = 3'd2,
        OP_VSYNC = 3'd3,
        OP_NOP   = 3'd4,
        OP_INTR  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } op_e;

    typedef struct packed {
        logic              rd;
        logic              a0;
        logic [BYTE_W-1:0] data;
    } bus_req_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_INHIBIT
    } phase_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_XFER, SQ_STALL, SQ_FRAME, SQ_FXFER, SQ_VWAIT
    } seq_e;

    function automatic op_e cmd_op(input logic [CMD_W-1:0] w);
        return op_e'(w[OP_LSB +: OP_W]);
    endfunction

    function automatic logic cmd_a0(input logic [CMD_W-1:0] w);
        return w[A0_POS];
    endfunction

    function automatic logic [BYTE_W-1:0] cmd_byte(input logic [CMD_W-1:0] w);
        return w[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/spnl_bus.sv
module spnl_bus
    import spnl_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  bus_req_t          req,
    input  logic              abort,
    input  logic [TW-1:0]     t_setup,
    input  logic [TW-1:0]     t_pulse,
    input  logic [TW-1:0]     t_ohold,
    input  logic [TW-1:0]     t_inhibit,
    output logic              done,
    output logic              rd_done,
    output logic [BYTE_W-1:0] cap_data,
    output logic              cs_n,
    output logic              a0,
    output logic              rd_n,
    output logic              wr_n,
    output logic              oe,
    output logic [BYTE_W-1:0] dout,
    input  logic [BYTE_W-1:0] din
);

    phase_e        ph, ph_nx;
    logic [TW-1:0] cnt, cnt_nx;
    bus_req_t      cur;
    logic          last;
    logic          active;

    function automatic logic [TW-1:0] ld(input logic [TW-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    assign last = (cnt == '0);

    always_comb begin
        ph_nx  = ph;
        cnt_nx = last ? cnt : cnt - 1'b1;
        unique case (ph)
            PH_IDLE: begin
                cnt_nx = '0;
                if (go) begin
                    ph_nx  = PH_SETUP;
                    cnt_nx = ld(t_setup);
                end
            end
            PH_SETUP: if (last) begin
                if (abort) ph_nx = PH_IDLE;
                else begin
                    ph_nx  = PH_STROBE;
                    cnt_nx = ld(t_pulse);
                end
            end
            PH_STROBE: if (last) begin
                if (abort) ph_nx = PH_IDLE;
                else begin
                    ph_nx  = PH_HOLD;
                    cnt_nx = cur.rd ? ld(t_ohold) : ld(t_setup);
                end
            end
            PH_HOLD: if (last) begin
                if (cur.rd || abort) ph_nx = PH_IDLE;
                else begin
                    ph_nx  = PH_INHIBIT;
                    cnt_nx = ld(t_inhibit);
                end
            end
            PH_INHIBIT: if (last) ph_nx = PH_IDLE;
            default: ph_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            cnt      <= '0;
            cur      <= '0;
            cap_data <= '0;
        end else begin
            ph  <= ph_nx;
            cnt <= cnt_nx;
            if (ph == PH_IDLE && go) cur <= req;
            if (ph == PH_STROBE && last && cur.rd) cap_data <= din;
        end
    end

    assign active  = (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
    assign done    = (ph != PH_IDLE) && (ph_nx == PH_IDLE);
    assign rd_done = done && cur.rd && (ph == PH_HOLD);
    assign cs_n    = !active;
    assign a0      = active && cur.a0;
    assign rd_n    = !((ph == PH_STROBE) && cur.rd);
    assign wr_n    = !((ph == PH_STROBE) && !cur.rd);
    assign oe      = active && !cur.rd;
    assign dout    = cur.data;

endmodule

// File: rtl/spnl_stat.sv
module spnl_stat
    import spnl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_rd,
    input  logic [BYTE_W-1:0] rd_byte,
    input  logic              rd_a0,
    input  logic              set_int,
    input  logic              set_err,
    input  logic              clr_we,
    input  logic [FLAG_N-1:0] clr_bits,
    input  logic              cont_set,
    input  logic              proceed,
    output logic [FLAG_N-1:0] flags,
    output logic [RDST_W-1:0] rdstat
);

    logic [FLAG_N-1:0] sets;
    logic [BYTE_W-1:0] r_byte;
    logic              r_a0, r_ok, r_cont;

    assign sets = {set_err, set_int, set_rd};

    always_ff @(posedge clk) begin
        if (rst) begin
            flags  <= '0;
            r_byte <= '0;
            r_a0   <= 1'b0;
            r_ok   <= 1'b0;
            r_cont <= 1'b0;
        end else begin
            flags  <= sets | (flags & ~({FLAG_N{clr_we}} & clr_bits));
            r_cont <= cont_set | (r_cont & ~proceed);
            if (set_rd) begin
                r_byte <= rd_byte;
                r_a0   <= rd_a0;
                r_ok   <= 1'b1;
            end else if (proceed) begin
                r_ok   <= 1'b0;
            end
        end
    end

    assign rdstat = {r_cont, r_ok, r_a0, r_byte};

endmodule

// File: rtl/spnl_seq.sv
module spnl_seq
    import spnl_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    output logic              cmd_ready,
    input  logic              pix_valid,
    input  logic [BYTE_W-1:0] pix_data,
    input  logic              pix_last,
    output logic              pix_ready,
    input  logic              vsync,
    input  logic              wait_abort,
    input  logic              cont_set,
    input  logic              sts_clr_we,
    input  logic [15:0]       sts_clr,
    input  logic [TW-1:0]     t_setup,
    input  logic [TW-1:0]     t_pulse,
    input  logic [TW-1:0]     t_ohold,
    input  logic [TW-1:0]     t_inhibit,
    output logic [15:0]       status,
    output logic [RDST_W-1:0] rdstat,
    output logic              irq,
    output logic              pnl_cs_n,
    output logic              pnl_a0,
    output logic              pnl_rd_n,
    output logic              pnl_wr_n,
    output logic              pnl_oe,
    output logic [BYTE_W-1:0] pnl_dout,
    input  logic [BYTE_W-1:0] pnl_din
);

    seq_e              sq, sq_nx;
    logic              last_pix, last_pix_nx;
    logic              acc, go, done, rd_done;
    logic              set_int, set_err, proceed;
    bus_req_t          req;
    op_e               op;
    logic [BYTE_W-1:0] cap_data;
    logic [FLAG_N-1:0] flags;
    logic [3:0]        spare_unused;
    logic [12:0]       clr_unused;

    assign spare_unused = cmd_word[CMD_W-1:OP_LSB+OP_W];
    assign clr_unused   = {sts_clr[15:FLAG_LSB+FLAG_N], sts_clr[FLAG_LSB-1:0]};

    assign op        = cmd_op(cmd_word);
    assign cmd_ready = enable && (sq == SQ_IDLE);
    assign pix_ready = enable && (sq == SQ_FRAME);
    assign acc       = cmd_valid && cmd_ready;

    always_comb begin
        sq_nx       = sq;
        last_pix_nx = last_pix;
        go          = 1'b0;
        req         = '0;
        set_int     = 1'b0;
        set_err     = 1'b0;
        proceed     = 1'b0;
        unique case (sq)
            SQ_IDLE: if (acc) begin
                unique case (op)
                    OP_READ, OP_WRITE: begin
                        go    = 1'b1;
                        req   = '{rd: (op == OP_READ), a0: cmd_a0(cmd_word),
                                  data: cmd_byte(cmd_word)};
                        sq_nx = SQ_XFER;
                    end
                    OP_FRAME: sq_nx = SQ_FRAME;
                    OP_VSYNC: sq_nx = SQ_VWAIT;
                    OP_NOP:   ;
                    OP_INTR:  set_int = 1'b1;
                    default:  set_err = 1'b1;
                endcase
            end
            SQ_XFER: if (done) sq_nx = rd_done ? SQ_STALL : SQ_IDLE;
            SQ_STALL: begin
                if (!enable) sq_nx = SQ_IDLE;
                else if (rdstat[RDST_W-1]) begin
                    proceed = 1'b1;
                    sq_nx   = SQ_IDLE;
                end
            end
            SQ_FRAME: begin
                if (!enable) sq_nx = SQ_IDLE;
                else if (pix_valid) begin
                    go          = 1'b1;
                    req         = '{rd: 1'b0, a0: 1'b1, data: pix_data};
                    last_pix_nx = pix_last;
                    sq_nx       = SQ_FXFER;
                end
            end
            SQ_FXFER: if (done) sq_nx = (last_pix || !enable) ? SQ_IDLE : SQ_FRAME;
            SQ_VWAIT: if (!enable || vsync || wait_abort) sq_nx = SQ_IDLE;
            default: sq_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sq       <= SQ_IDLE;
            last_pix <= 1'b0;
        end else begin
            sq       <= sq_nx;
            last_pix <= last_pix_nx;
        end
    end

    spnl_bus #(.TW(TW)) u_bus (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .req       (req),
        .abort     (!enable),
        .t_setup   (t_setup),
        .t_pulse   (t_pulse),
        .t_ohold   (t_ohold),
        .t_inhibit (t_inhibit),
        .done      (done),
        .rd_done   (rd_done),
        .cap_data  (cap_data),
        .cs_n      (pnl_cs_n),
        .a0        (pnl_a0),
        .rd_n      (pnl_rd_n),
        .wr_n      (pnl_wr_n),
        .oe        (pnl_oe),
        .dout      (pnl_dout),
        .din       (pnl_din)
    );

    spnl_stat u_stat (
        .clk      (clk),
        .rst      (rst),
        .set_rd   (rd_done),
        .rd_byte  (cap_data),
        .rd_a0    (pnl_a0),
        .set_int  (set_int),
        .set_err  (set_err),
        .clr_we   (sts_clr_we),
        .clr_bits (sts_clr[FLAG_LSB +: FLAG_N]),
        .cont_set (cont_set),
        .proceed  (proceed),
        .flags    (flags),
        .rdstat   (rdstat)
    );

    always_comb begin
        status = '0;
        status[FLAG_LSB +: FLAG_N] = flags;
    end

    assign irq = flags[1];

endmodule

// File: rtl/spnl_seq_chk.sv
module spnl_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        enable,
    input logic        cmd_ready,
    input logic        pix_ready,
    input logic        cont_set,
    input logic        sts_clr_we,
    input logic [15:0] sts_clr,
    input logic [15:0] status,
    input logic [10:0] rdstat,
    input logic        pnl_cs_n,
    input logic        pnl_rd_n,
    input logic        pnl_wr_n,
    input logic        pnl_oe
);

    p_off_no_accept_r1: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (!cmd_ready && !pix_ready));

    p_wr_inside_cs_r2: assert property (@(posedge clk) disable iff (rst)
        !pnl_wr_n |-> (!pnl_cs_n && pnl_oe));

    p_single_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        (pnl_rd_n || pnl_wr_n));

    p_read_undriven_r5: assert property (@(posedge clk) disable iff (rst)
        !pnl_rd_n |-> (!pnl_oe && !pnl_cs_n));

    p_cont_takes_r6: assert property (@(posedge clk) disable iff (rst)
        cont_set |=> rdstat[10]);

    p_int_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (status[12] && !(sts_clr_we && sts_clr[12])) |=> status[12]);

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (status[13] && !(sts_clr_we && sts_clr[13])) |=> status[13]);

    p_off_stays_idle_r12: assert property (@(posedge clk) disable iff (rst)
        (!enable && pnl_cs_n) |=> pnl_cs_n);

endmodule

bind spnl_seq spnl_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .cmd_ready  (cmd_ready),
    .pix_ready  (pix_ready),
    .cont_set   (cont_set),
    .sts_clr_we (sts_clr_we),
    .sts_clr    (sts_clr),
    .status     (status),
    .rdstat     (rdstat),
    .pnl_cs_n   (pnl_cs_n),
    .pnl_rd_n   (pnl_rd_n),
    .pnl_wr_n   (pnl_wr_n),
    .pnl_oe     (pnl_oe)
);

// File: tb/spnl_seq_tb.sv
module spnl_seq_tb_top;

    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enable = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [15:0]   cmd_word = '0;
    logic          cmd_ready;
    logic          pix_valid = 1'b0;
    logic [7:0]    pix_data = '0;
    logic          pix_last = 1'b0;
    logic          pix_ready;
    logic          vsync = 1'b0;
    logic          wait_abort = 1'b0;
    logic          cont_set = 1'b0;
    logic          sts_clr_we = 1'b0;
    logic [15:0]   sts_clr = '0;
    logic [TW-1:0] t_setup = 8'd1, t_pulse = 8'd1, t_ohold = 8'd1, t_inhibit = 8'd1;
    logic [15:0]   status;
    logic [10:0]   rdstat;
    logic          irq;
    logic          pnl_cs_n, pnl_a0, pnl_rd_n, pnl_wr_n, pnl_oe;
    logic [7:0]    pnl_dout;
    logic [7:0]    pnl_din = '0;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    spnl_seq #(.TW(TW)) dut_i (.*);

    // bus monitor: one log entry per chip-select window
    logic [7:0] lg_byte [64];
    bit         lg_rd   [64];
    bit         lg_a0   [64];
    int         lg_su [64], lg_st [64], lg_ho [64], lg_gap [64];
    int         lg_n = 0;
    bit         in_x = 0;
    int         m_su, m_st, m_ho, m_gap = 1000, m_gapv;
    logic [7:0] m_byte;
    bit         m_rd, m_a0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!pnl_cs_n) begin
                if (!in_x) begin
                    in_x = 1; m_su = 0; m_st = 0; m_ho = 0; m_gapv = m_gap;
                end
                if (!pnl_wr_n || !pnl_rd_n) begin
                    m_st++; m_rd = !pnl_rd_n; m_a0 = pnl_a0;
                    m_byte = pnl_rd_n ? pnl_dout : 8'h00;
                end else if (m_st == 0) m_su++;
                else m_ho++;
            end else begin
                if (in_x) begin
                    lg_byte[lg_n % 64] = m_byte; lg_rd[lg_n % 64] = m_rd;
                    lg_a0[lg_n % 64] = m_a0; lg_su[lg_n % 64] = m_su;
                    lg_st[lg_n % 64] = m_st; lg_ho[lg_n % 64] = m_ho;
                    lg_gap[lg_n % 64] = m_gapv;
                    lg_n++; in_x = 0; m_gap = 0;
                end
                m_gap++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic eq(input string tag, input string what, input int act, input int exp);
        chk(act == exp, tag, what, act, exp);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] w);
        int t = 0;
        cmd_word = w; cmd_valid = 1'b1;
        while (!cmd_ready && t < 5000) begin @(negedge clk); t++; end
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pix(input logic [7:0] b, input logic l);
        int t = 0;
        pix_data = b; pix_last = l; pix_valid = 1'b1;
        while (!pix_ready && t < 5000) begin @(negedge clk); t++; end
        @(negedge clk);
        pix_valid = 1'b0; pix_last = 1'b0;
    endtask

    task automatic clr(input logic [15:0] m);
        sts_clr_we = 1'b1; sts_clr = m;
        @(negedge clk);
        sts_clr_we = 1'b0; sts_clr = '0;
    endtask

    task automatic xfer(input string tag, input int i, input bit rd, input bit a0, input int b,
                        input int su, input int st, input int ho);
        eq(tag, "rd", lg_rd[i % 64], rd);
        eq(tag, "a0", lg_a0[i % 64], a0);
        if (!rd) eq(tag, "byte", lg_byte[i % 64], b);
        eq(tag, "setup", lg_su[i % 64], su);
        eq(tag, "strobe", lg_st[i % 64], st);
        eq(tag, "hold", lg_ho[i % 64], ho);
    endtask

    task automatic t_reset;
        eq("R1", "cs_n", pnl_cs_n, 1); eq("R1", "rd_n", pnl_rd_n, 1);
        eq("R1", "wr_n", pnl_wr_n, 1); eq("R1", "oe", pnl_oe, 0);
        eq("R1", "status", status, 0); eq("R1", "rdstat", rdstat, 0); eq("R1", "irq", irq, 0);
        cmd_word = 16'h0255; cmd_valid = 1'b1;
        cyc(8);
        eq("R1", "cmd_ready off", cmd_ready, 0); eq("R1", "pix_ready off", pix_ready, 0);
        eq("R1", "no transfer off", lg_n, 0);
        cmd_valid = 1'b0;
    endtask

    task automatic t_write;
        int n0 = lg_n;
        t_setup = 2; t_pulse = 3; t_inhibit = 4;
        send(16'h023C); send(16'h03A7);
        cyc(30);
        eq("R2", "count", lg_n - n0, 2);
        xfer("R2", n0, 0, 0, 8'h3C, 2, 3, 2);
        xfer("R3", n0 + 1, 0, 1, 8'hA7, 2, 3, 2);
        chk(lg_gap[(n0 + 1) % 64] >= 4, "R4", "inhibit gap", lg_gap[(n0 + 1) % 64], 4);
    endtask

    task automatic t_zero;
        int n0 = lg_n;
        t_setup = 0; t_pulse = 0; t_inhibit = 0;
        send(16'h0281); send(16'h0382);
        cyc(20);
        xfer("R3", n0, 0, 0, 8'h81, 1, 1, 1);
        chk(lg_gap[(n0 + 1) % 64] >= 1, "R4", "zero inhibit gap", lg_gap[(n0 + 1) % 64], 1);
    endtask

    task automatic t_read;
        int n0 = lg_n;
        t_setup = 1; t_pulse = 2; t_ohold = 3; t_inhibit = 1;
        pnl_din = 8'h5E;
        send(16'h0100);
        fork
            send(16'h0211);
            begin
                cyc(30);
                eq("R6", "stalled count", lg_n - n0, 1);
                xfer("R5", n0, 1, 1, 0, 1, 2, 3);
                eq("R5", "rdstat", rdstat, 11'h35E);
                eq("R5", "status rd bit", status[11], 1);
                cont_set = 1'b1; @(negedge clk); cont_set = 1'b0;
            end
        join
        cyc(20);
        eq("R6", "resumed count", lg_n - n0, 2);
        eq("R6", "resumed byte", lg_byte[(n0 + 1) % 64], 8'h11);
        eq("R6", "ok/cont cleared", rdstat[10:9], 0);
        clr(16'h0800);
        eq("R10", "w1c rd bit", status[11], 0);
    endtask

    task automatic t_prearm;
        int n0 = lg_n;
        pnl_din = 8'hC3;
        cont_set = 1'b1; @(negedge clk); cont_set = 1'b0;
        eq("R6", "prearmed flag", rdstat[10], 1);
        send(16'h0000); send(16'h0233);
        cyc(30);
        eq("R6", "prearm count", lg_n - n0, 2);
        eq("R5", "status read a0", lg_a0[n0 % 64], 0);
        eq("R6", "prearm next byte", lg_byte[(n0 + 1) % 64], 8'h33);
        eq("R5", "data kept", rdstat[7:0], 8'hC3);
        eq("R6", "flags cleared", rdstat[10:9], 0);
        clr(16'hFFFF);
    endtask

    task automatic t_frame;
        int n0 = lg_n;
        send(16'h0500);
        pix(8'h11, 0); pix(8'h22, 0); pix(8'h33, 1);
        send(16'h02FF);
        cyc(30);
        eq("R7", "count", lg_n - n0, 4);
        for (int i = 0; i < 3; i++) begin
            eq("R7", "pixel a0", lg_a0[(n0 + i) % 64], 1);
            eq("R7", "pixel byte", lg_byte[(n0 + i) % 64], 8'h11 * (i + 1));
        end
        eq("R7", "after frame a0", lg_a0[(n0 + 3) % 64], 0);
        eq("R7", "after frame byte", lg_byte[(n0 + 3) % 64], 8'hFF);
    endtask

    task automatic t_vsync;
        int n0 = lg_n;
        send(16'h0600);
        fork
            send(16'h0299);
            begin
                cyc(20);
                eq("R8", "held before vsync", lg_n - n0, 0);
                vsync = 1'b1; @(negedge clk); vsync = 1'b0;
            end
        join
        cyc(15);
        eq("R8", "after vsync", lg_n - n0, 1);
        n0 = lg_n;
        send(16'h0600);
        fork
            send(16'h0298);
            begin
                cyc(20);
                eq("R8", "held before abort", lg_n - n0, 0);
                wait_abort = 1'b1; @(negedge clk); wait_abort = 1'b0;
            end
        join
        cyc(15);
        eq("R8", "after abort", lg_n - n0, 1);
    endtask

    task automatic t_noop;
        int n0 = lg_n;
        logic [15:0] s0 = status;
        send(16'h0800); send(16'h0955);
        cyc(15);
        eq("R9", "no bus", lg_n - n0, 0);
        eq("R9", "no status change", status, s0);
    endtask

    task automatic t_irq;
        int n0 = lg_n;
        send(16'h0A00);
        cyc(3);
        eq("R10", "int bit", status[12], 1); eq("R10", "irq", irq, 1);
        eq("R10", "no bus", lg_n - n0, 0);
        clr(16'h1000);
        eq("R10", "cleared", status[12], 0); eq("R10", "irq cleared", irq, 0);
        send(16'h0A00);
        cyc(2);
        while (!cmd_ready) @(negedge clk);
        cmd_word = 16'h0A00; cmd_valid = 1'b1;
        sts_clr_we = 1'b1; sts_clr = 16'h1000;
        @(negedge clk);
        cmd_valid = 1'b0; sts_clr_we = 1'b0; sts_clr = '0;
        eq("R10", "set beats clear", status[12], 1);
        eq("R10", "irq after race", irq, 1);
        clr(16'h1000);
    endtask

    task automatic t_badop;
        int n0 = lg_n;
        send(16'h0C00);
        cyc(3);
        eq("R11", "err op6", status[13], 1);
        clr(16'h2000);
        eq("R11", "err cleared", status[13], 0);
        send(16'h0F12);
        cyc(3);
        eq("R11", "err op7", status[13], 1);
        eq("R11", "no bus", lg_n - n0, 0);
        clr(16'h2000);
    endtask

    task automatic t_disable;
        int n0 = lg_n;
        int t = 0;
        t_setup = 2; t_pulse = 6; t_inhibit = 2;
        send(16'h0242);
        while (pnl_wr_n && t < 100) begin @(negedge clk); t++; end
        @(negedge clk);
        enable = 1'b0;
        cmd_word = 16'h0243; cmd_valid = 1'b1;
        cyc(25);
        eq("R12", "one transfer", lg_n - n0, 1);
        eq("R12", "strobe full", lg_st[n0 % 64], 6);
        eq("R12", "no hold", lg_ho[n0 % 64], 0);
        eq("R12", "cs idle", pnl_cs_n, 1);
        eq("R1", "ready off", cmd_ready, 0);
        cmd_valid = 1'b0;
        enable = 1'b1;
        cyc(2);
    endtask

    initial begin
        cyc(5);
        rst = 1'b0;
        cyc(2);
        t_reset();
        enable = 1'b1;
        cyc(2);
        t_write();
        t_zero();
        t_read();
        t_prearm();
        t_frame();
        t_vsync();
        t_noop();
        t_irq();
        t_badop();
        t_disable();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule